// File: doc/BRIEF.md
# Dual Event-Selectable Performance Counters

Two 32-bit counters sit behind one shared control word. Each counter has a 5-bit event code that picks one of seven pipeline strobes (cycle, instruction issued, branch issued, instruction completed, non-delay-slot completed, coprocessor op completed, load/store completed), or picks nothing. In every clock cycle where the chosen strobe is high and the counter is enabled, the counter goes up by one. Software reads and writes the control word and both counters through a small access port that uses a sub-select code.

Each counter raises its own overflow request while its top bit is set. The request also needs the global enable bit in the control word and the error-level status input. The request is a plain level. It stays high until software rewrites the counter. The block does not vector to any handler. It only provides the request.

Top module: `perf_counter_pair`

## Requirements
- R1: Event codes map to strobes as follows: 1 to evt_i[0] (cycle), 2 to evt_i[1] (issue), 3 to evt_i[2] (branch), 12 to evt_i[3] (completed), 13 to evt_i[4] (non-delay-slot completed), 14 to evt_i[5] (coprocessor completed), 15 to evt_i[6] (load/store completed). An enabled counter adds one in a cycle where its mapped strobe is high.
- R2: Event codes 0, 4 to 11, 16 and 17 to 31 never count, on either counter, whatever the strobes do.
- R3: Counter 0 counts only while at least one of control bits [3:0] is set. Counter 1 counts only while control bit 9 is set.
- R4: A counter gains exactly one per counted cycle and wraps from 0xFFFFFFFF to 0 without saturating.
- R5: An access takes place only when acc_en_i is high. Sub-select 0 is the control word, 1 is counter 0 and 3 is counter 1. Any other sub-select reads as 0 and ignores writes. A write needs acc_we_i high.
- R6: The control word keeps bits [3:0] (counter 0 enables), [8:4] (counter 0 event code), [9] (counter 1 enable), [14:10] (counter 1 event code) and [31] (global enable). All other bits read back as 0.
- R7: A write to a counter replaces its value and drops any event in that cycle. Counting resumes from the written value in the next cycle.
- R8: A control write takes effect from the next cycle. An event in the write cycle is counted under the old settings.
- R9: ovf_req_o[i] is high exactly while bit 31 of counter i, control bit 31 and erl_i are all high. It holds until the counter is rewritten.
- R10: Reset clears both counters and the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Per-cycle event strobes from the pipeline |
| erl_i | input | 1 | Error-level status, gates the overflow requests |
| acc_en_i | input | 1 | Register access valid |
| acc_we_i | input | 1 | Access is a write |
| acc_sel_i | input | 6 | Access sub-select |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data for the current sub-select |
| ovf_req_o | output | 2 | Overflow request per counter |

## Verification
Two collisions matter here: an event strobe in the same cycle as a write to that counter, and an event strobe in the same cycle as a control write that turns the counter off. The bench provokes each by driving the strobe and the access in one cycle. It then reads the counter back: the written value with no increment in the first case, and the old setting's increment followed by no further counting in the second. The overflow level is also checked across changes of erl_i, of the global enable and of the counter value.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int EVT_W  = 7;
  localparam int SEL_W  = 5;
  localparam int CTRL_W = 32;

  // strobe bit positions on evt_i
  localparam int STB_CYCLE   = 0;
  localparam int STB_ISSUE   = 1;
  localparam int STB_BRANCH  = 2;
  localparam int STB_DONE    = 3;
  localparam int STB_DONE_ND = 4;
  localparam int STB_DONE_CP = 5;
  localparam int STB_DONE_LS = 6;

  typedef enum logic [SEL_W-1:0] {
    EV_OFF     = 5'd0,
    EV_CYCLE   = 5'd1,
    EV_ISSUE   = 5'd2,
    EV_BRANCH  = 5'd3,
    EV_DONE    = 5'd12,
    EV_DONE_ND = 5'd13,
    EV_DONE_CP = 5'd14,
    EV_DONE_LS = 5'd15,
    EV_STOP    = 5'd16
  } evt_code_e;

  localparam int SUB_CTRL = 0;
  localparam int SUB_CNT0 = 1;
  localparam int SUB_CNT1 = 3;

  typedef struct packed {
    logic             gbl_en;
    logic [15:0]      rsvd;
    logic [SEL_W-1:0] sel1;
    logic             en1;
    logic [SEL_W-1:0] sel0;
    logic [3:0]       en0;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h8000_7FFF;
endpackage

// File: rtl/perf_evt_decode.sv
module perf_evt_decode
  import perf_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [EVT_W-1:0] stb_i,
  output logic             hit_o
);
  always_comb begin
    unique case (sel_i)
      EV_CYCLE:   hit_o = stb_i[STB_CYCLE];
      EV_ISSUE:   hit_o = stb_i[STB_ISSUE];
      EV_BRANCH:  hit_o = stb_i[STB_BRANCH];
      EV_DONE:    hit_o = stb_i[STB_DONE];
      EV_DONE_ND: hit_o = stb_i[STB_DONE_ND];
      EV_DONE_CP: hit_o = stb_i[STB_DONE_CP];
      EV_DONE_LS: hit_o = stb_i[STB_DONE_LS];
      default:    hit_o = 1'b0; // off, uncounted, stop, reserved
    endcase
  end
endmodule

// File: rtl/perf_cnt_reg.sv
module perf_cnt_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wr_i)  q_o <= wdata_i;  // write wins over a same-cycle event
    else if (inc_i) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/perf_ctrl_reg.sv
module perf_ctrl_reg
  import perf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= ctrl_t'(wdata_i & CTRL_MASK);
  end
endmodule

// File: rtl/perf_counter_pair.sv
module perf_counter_pair
  import perf_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SUB_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             erl_i,
  input  logic             acc_en_i,
  input  logic             acc_we_i,
  input  logic [SUB_W-1:0] acc_sel_i,
  input  logic [CNT_W-1:0] acc_wdata_i,
  output logic [CNT_W-1:0] acc_rdata_o,
  output logic [1:0]       ovf_req_o
);
  localparam int NUM_CNT = 2;

  ctrl_t              ctrl_q;
  logic [CTRL_W-1:0]  ctrl_word;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic               wr_ctrl;

  assign ctrl_word = ctrl_q;
  assign wr_ctrl   = acc_en_i && acc_we_i && (acc_sel_i == SUB_W'(SUB_CTRL));

  perf_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .wdata_i (acc_wdata_i[CTRL_W-1:0]),
    .q_o     (ctrl_q)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int MY_SUB = (i == 0) ? SUB_CNT0 : SUB_CNT1;
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             hit;
    logic             wr;

    if (i == 0) begin : g_en0
      assign sel = ctrl_q.sel0;
      assign en  = |ctrl_q.en0;
    end else begin : g_en1
      assign sel = ctrl_q.sel1;
      assign en  = ctrl_q.en1;
    end

    assign wr = acc_en_i && acc_we_i && (acc_sel_i == SUB_W'(MY_SUB));

    perf_evt_decode u_dec (
      .sel_i (sel),
      .stb_i (evt_i),
      .hit_o (hit)
    );

    perf_cnt_reg #(.W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr),
      .wdata_i (acc_wdata_i),
      .inc_i   (en && hit),
      .q_o     (cnt_q[i])
    );

    // level request, held while MSB stays set
    assign ovf_req_o[i] = cnt_q[i][CNT_W-1] && ctrl_q.gbl_en && erl_i;
  end

  always_comb begin
    if (acc_sel_i == SUB_W'(SUB_CTRL))      acc_rdata_o = CNT_W'(ctrl_word);
    else if (acc_sel_i == SUB_W'(SUB_CNT0)) acc_rdata_o = cnt_q[0];
    else if (acc_sel_i == SUB_W'(SUB_CNT1)) acc_rdata_o = cnt_q[1];
    else                                    acc_rdata_o = '0;
  end
endmodule

// File: rtl/perf_counter_pair_chk.sv
module perf_counter_pair_chk #(
  parameter int CNT_W = 32,
  parameter int SUB_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_en_i,
  input logic             acc_we_i,
  input logic [SUB_W-1:0] acc_sel_i,
  input logic [CNT_W-1:0] acc_wdata_i,
  input logic [1:0]       ovf_req_o,
  input logic [31:0]      ctrl_i,
  input logic [CNT_W-1:0] cnt0_i,
  input logic [CNT_W-1:0] cnt1_i
);
  logic wr0, wr1, wr_hole;
  assign wr0     = acc_en_i && acc_we_i && (acc_sel_i == SUB_W'(1));
  assign wr1     = acc_en_i && acc_we_i && (acc_sel_i == SUB_W'(3));
  assign wr_hole = acc_en_i && acc_we_i && (acc_sel_i == SUB_W'(2));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr0 |=> (cnt0_i == $past(cnt0_i)) || (cnt0_i == $past(cnt0_i) + 1'b1));

  assert_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> cnt0_i == $past(acc_wdata_i));

  assert_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[3:0] == 4'd0 && !wr0) |=> cnt0_i == $past(cnt0_i));

  assert_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[14:10] >= 5'd16 && !wr1) |=> cnt1_i == $past(cnt1_i));

  assert_hole_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hole |=> (ctrl_i == $past(ctrl_i)) && (cnt1_i == $past(cnt1_i)));

  assert_gbl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[31] |-> ovf_req_o == 2'b00);

  assert_msb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_req_o[1] |-> cnt1_i[CNT_W-1]);
endmodule

bind perf_counter_pair perf_counter_pair_chk #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_en_i    (acc_en_i),
  .acc_we_i    (acc_we_i),
  .acc_sel_i   (acc_sel_i),
  .acc_wdata_i (acc_wdata_i),
  .ovf_req_o   (ovf_req_o),
  .ctrl_i      (ctrl_word),
  .cnt0_i      (cnt_q[0]),
  .cnt1_i      (cnt_q[1])
);

// File: tb/perf_counter_pair_bench.sv
module perf_counter_pair_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] en0;
    logic [4:0] s0;
    logic       en1;
    logic [4:0] s1;
    logic [6:0] evt;
    logic       e0;
    logic       e1;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'h1, 5'd1,  1'b1, 5'd2,  7'b0000011, 1'b1, 1'b1},
    '{4'h2, 5'd3,  1'b1, 5'd3,  7'b0000001, 1'b0, 1'b0},
    '{4'h4, 5'd12, 1'b1, 5'd13, 7'b0011000, 1'b1, 1'b1},
    '{4'h8, 5'd14, 1'b1, 5'd15, 7'b1100000, 1'b1, 1'b1},
    '{4'h1, 5'd4,  1'b1, 5'd11, 7'b1111111, 1'b0, 1'b0},
    '{4'h1, 5'd0,  1'b1, 5'd16, 7'b1111111, 1'b0, 1'b0},
    '{4'h1, 5'd20, 1'b1, 5'd31, 7'b1111111, 1'b0, 1'b0},
    '{4'h0, 5'd1,  1'b1, 5'd1,  7'b0000001, 1'b0, 1'b1},
    '{4'hF, 5'd1,  1'b0, 5'd1,  7'b0000001, 1'b1, 1'b0},
    '{4'h1, 5'd15, 1'b1, 5'd12, 7'b1000000, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        erl = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_we = 1'b0;
  logic [5:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ovf;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_pair u_perf_counter_pair (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .evt_i       (evt),
    .erl_i       (erl),
    .acc_en_i    (acc_en),
    .acc_we_i    (acc_we),
    .acc_sel_i   (acc_sel),
    .acc_wdata_i (acc_wdata),
    .acc_rdata_o (rdata),
    .ovf_req_o   (ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic we, input logic [5:0] sel,
                     input logic [31:0] d, input logic [6:0] ev);
    @(negedge clk);
    acc_en = en; acc_we = we; acc_sel = sel; acc_wdata = d; evt = ev;
  endtask

  task automatic rd(input logic [5:0] sel, output logic [31:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_sel = sel; acc_wdata = '0; evt = '0;
    #1 v = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cw;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    rd(6'd0, v); check("R10 ctrl", v, 32'h0);
    rd(6'd1, v); check("R10 cnt0", v, 32'h0);
    rd(6'd3, v); check("R10 cnt1", v, 32'h0);
    check("R10 ovf", {30'd0, ovf}, 32'h0);

    // table walk: R1 R2 R3
    for (int k = 0; k < NV; k++) begin
      cw = {1'b0, 16'd0, VEC[k].s1, VEC[k].en1, VEC[k].s0, VEC[k].en0};
      cyc(1'b1, 1'b1, 6'd0, cw, 7'd0);
      cyc(1'b1, 1'b1, 6'd1, 32'd0, 7'd0);
      cyc(1'b1, 1'b1, 6'd3, 32'd0, 7'd0);
      cyc(1'b0, 1'b0, 6'd0, 32'd0, VEC[k].evt);
      rd(6'd1, v); check($sformatf("R1/R2/R3 vec%0d cnt0", k), v, {31'd0, VEC[k].e0});
      rd(6'd3, v); check($sformatf("R1/R2/R3 vec%0d cnt1", k), v, {31'd0, VEC[k].e1});
    end

    // R6 control readback of implemented bits only
    cyc(1'b1, 1'b1, 6'd0, 32'hFFFF_FFFF, 7'd0);
    rd(6'd0, v); check("R6 ctrl mask", v, 32'h8000_7FFF);

    // R7 counter write collides with an event
    cyc(1'b1, 1'b1, 6'd0, 32'h0000_0011, 7'd0);
    cyc(1'b1, 1'b1, 6'd1, 32'd100, 7'h01);
    rd(6'd1, v); check("R7 write wins", v, 32'd100);
    cyc(1'b0, 1'b0, 6'd0, 32'd0, 7'h01);
    rd(6'd1, v); check("R7 resume", v, 32'd101);

    // R8 control write collides with an event
    cyc(1'b1, 1'b1, 6'd0, 32'h0, 7'h01);
    rd(6'd1, v); check("R8 old settings", v, 32'd102);
    cyc(1'b0, 1'b0, 6'd0, 32'd0, 7'h01);
    rd(6'd1, v); check("R8 new settings", v, 32'd102);

    // R4 accumulation and wrap
    cyc(1'b1, 1'b1, 6'd0, 32'h0000_0011, 7'd0);
    cyc(1'b1, 1'b1, 6'd1, 32'd0, 7'd0);
    for (int j = 0; j < 5; j++) cyc(1'b0, 1'b0, 6'd0, 32'd0, 7'h01);
    rd(6'd1, v); check("R4 accumulate", v, 32'd5);
    cyc(1'b1, 1'b1, 6'd1, 32'hFFFF_FFFF, 7'd0);
    cyc(1'b0, 1'b0, 6'd0, 32'd0, 7'h01);
    rd(6'd1, v); check("R4 wrap", v, 32'd0);

    // R5 unused sub-select and gated access
    cyc(1'b1, 1'b1, 6'd1, 32'd7, 7'd0);
    cyc(1'b1, 1'b1, 6'd2, 32'hDEAD_BEEF, 7'd0);
    rd(6'd2, v); check("R5 hole reads zero", v, 32'd0);
    rd(6'd0, v); check("R5 hole write ctrl", v, 32'h0000_0011);
    rd(6'd1, v); check("R5 hole write cnt0", v, 32'd7);
    cyc(1'b0, 1'b1, 6'd1, 32'd55, 7'd0);
    rd(6'd1, v); check("R5 no enable", v, 32'd7);

    // R9 overflow level
    cyc(1'b1, 1'b1, 6'd0, 32'h8000_0600, 7'd0);
    @(negedge clk) erl = 1'b1;
    cyc(1'b1, 1'b1, 6'd3, 32'h7FFF_FFFF, 7'd0);
    rd(6'd3, v); check("R9 below msb", {30'd0, ovf}, 32'h0);
    cyc(1'b0, 1'b0, 6'd0, 32'd0, 7'h01);
    rd(6'd3, v); check("R9 cnt1 value", v, 32'h8000_0000);
    check("R9 raised", {30'd0, ovf}, 32'h2);
    cyc(1'b0, 1'b0, 6'd0, 32'd0, 7'h00);
    cyc(1'b0, 1'b0, 6'd0, 32'd0, 7'h00);
    #1 check("R9 held", {30'd0, ovf}, 32'h2);
    @(negedge clk) erl = 1'b0;
    #1 check("R9 erl low", {30'd0, ovf}, 32'h0);
    @(negedge clk) erl = 1'b1;
    cyc(1'b1, 1'b1, 6'd0, 32'h0000_0600, 7'd0);
    rd(6'd3, v); check("R9 gbl off", {30'd0, ovf}, 32'h0);
    cyc(1'b1, 1'b1, 6'd0, 32'h8000_0600, 7'd0);
    rd(6'd3, v); check("R9 gbl on", {30'd0, ovf}, 32'h2);
    cyc(1'b1, 1'b1, 6'd3, 32'd0, 7'd0);
    rd(6'd3, v); check("R9 cleared", {30'd0, ovf}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule